// File: doc/BRIEF.md
# Bus-Master DMA Burst Scheduler

This block decides when a network controller should take the host bus and how long it keeps it. It watches the occupancy of a transmit FIFO and a receive FIFO. From those levels and programmable watermarks it raises a bus request for one direction. Once the bus is granted, it issues one transfer strobe at a time. It stops the burst when the transfer count runs out, when the bus-activity timer expires, or when the FIFO in use reaches its threshold.

The transfer engine outside the block carries out each strobe as one 16-bit word move. It reports completion with a one-cycle done pulse, and the FIFO levels it presents already include that word. Address generation, descriptor handling and bus cycle timing belong to other blocks. The burst length comes from one of three sources. A plain count is the default. In fill mode the count is replaced by the FIFO thresholds. In timer mode the length is set by a 100 ns countdown. In every mode a transfer that would overrun a FIFO is never started.

Top module: `dma_burst_sched`

## Requirements
- R1: While rst_ni is low, bus_req_o, master_o and xfer_o are all 0, whatever the FIFO levels.
- R2: A receive request is raised when rx_level_i >= rx_wm_i and rx_level_i is nonzero. When the receive and transmit conditions both hold, the burst direction is receive (dir_o = 0).
- R3: A transmit request (dir_o = 1) is raised when the free words DEPTH - tx_level_i reach the coded watermark: code 00 needs 8 words, 01 needs 16, 10 needs 32, and the reserved code 11 is treated as 32. Below that level, no request is raised.
- R4: bus_req_o stays high until grant_i is sampled high. master_o rises the cycle after that sample and stays high for the whole burst, and dir_o does not change while master_o is high.
- R5: With fill mode and the timer both off, a burst makes burst_len_i transfers (1 to 255). A burst_len_i of 0 selects the default of 16 transfers.
- R6: In a transmit burst no transfer is started while tx_level_i >= tx_hi_i or the FIFO is full, even if the count is not exhausted.
- R7: In a receive burst no transfer is started while rx_level_i <= rx_lo_i.
- R8: With fill_mode_i set, burst_len_i is ignored and the burst runs until the threshold of R6 or R7 is met.
- R9: With timer_en_i set, timer_val_i is loaded at the grant, and burst_len_i is ignored. The value decrements once every TICK_DIV master-active cycles. The burst ends at the first transfer boundary after the value reaches zero, provided at least one transfer is done.
- R10: With the timer enabled and a value of zero, a burst makes exactly one transfer (unless a threshold stops it first).
- R11: xfer_o is a single-cycle pulse, and no new pulse is issued until xfer_done_i has reported the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | LW | Words held in the transmit FIFO |
| rx_level_i | input | LW | Words held in the receive FIFO |
| tx_hi_i | input | LW | Transmit high threshold (words) |
| rx_lo_i | input | LW | Receive low threshold (words) |
| rx_wm_i | input | LW | Receive request watermark (words) |
| tx_wm_code_i | input | 2 | Coded transmit request watermark |
| burst_len_i | input | 8 | Transfers per burst, 0 selects default |
| fill_mode_i | input | 1 | Run bursts to the FIFO threshold |
| timer_en_i | input | 1 | Enable bus-activity timer mode |
| timer_val_i | input | 16 | Timer reload in 100 ns ticks |
| grant_i | input | 1 | Bus grant |
| xfer_done_i | input | 1 | Pulse: current transfer completed |
| bus_req_o | output | 1 | Bus request |
| master_o | output | 1 | Master transfer in progress |
| xfer_o | output | 1 | Pulse: start one word transfer |
| dir_o | output | 1 | 1 = host to transmit FIFO, 0 = receive FIFO to host |

## Verification
The bench uses DEPTH = 64 and DEF_BURST = 16, so that a 255-count burst is cut short by the receive FIFO draining, and every transmit watermark code fits below the depth. TICK_DIV is set to 4 instead of 20. This lets a ten-tick timer burst finish in about forty cycles, so the expiry window can be checked exactly against the transfer boundary. The bench drives transfer latencies of one to three cycles and grant delays of several cycles, which exercises the one-outstanding rule and the held request.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_ISSUE,
    ST_WAIT
  } burst_st_e;

  // free write cycles required before a transmit request
  function automatic int unsigned tx_wm_words(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 32;  // 11 reserved, treated as 10
    endcase
  endfunction

endpackage

// File: rtl/dma_burst_arb.sv
module dma_burst_arb
  import dma_burst_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0] tx_level_i,
  input  logic [LW-1:0] rx_level_i,
  input  logic [LW-1:0] rx_wm_i,
  input  logic [1:0]    tx_wm_code_i,
  output logic          need_o,
  output logic          dir_tx_o
);

  logic [LW:0] tx_free;
  logic [LW:0] tx_wm;
  logic        rx_need;
  logic        tx_need;

  assign tx_free = (LW + 1)'(DEPTH) - {1'b0, tx_level_i};
  assign tx_wm   = (LW + 1)'(tx_wm_words(tx_wm_code_i));
  assign rx_need = (rx_level_i >= rx_wm_i) && (rx_level_i != '0);
  assign tx_need = tx_free >= tx_wm;

  assign need_o   = rx_need | tx_need;
  assign dir_tx_o = ~rx_need;  // receive wins a tie

endmodule

// File: rtl/dma_burst_timer.sv
module dma_burst_timer #(
  parameter int DIV = 20,
  parameter int TW  = 16,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          run_i,
  output logic          zero_o
);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tmr_q;
  logic          tick;

  assign tick = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      tmr_q <= val_i;
    end else if (run_i) begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (tick && tmr_q != '0) tmr_q <= tmr_q - TW'(1);
    end
  end

  assign zero_o = (tmr_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tmr_q == '0) |=> tmr_q == '0); // R9
  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tmr_q != '0) |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) - TW'(1))); // R9

endmodule

// File: rtl/dma_burst_sched.sv
module dma_burst_sched
  import dma_burst_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TICK_DIV  = 20,
  parameter int DEF_BURST = 16,
  parameter int CW        = 8,
  parameter int TW        = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] tx_level_i,
  input  logic [LW-1:0] rx_level_i,
  input  logic [LW-1:0] tx_hi_i,
  input  logic [LW-1:0] rx_lo_i,
  input  logic [LW-1:0] rx_wm_i,
  input  logic [1:0]    tx_wm_code_i,
  input  logic [CW-1:0] burst_len_i,
  input  logic          fill_mode_i,
  input  logic          timer_en_i,
  input  logic [TW-1:0] timer_val_i,
  input  logic          grant_i,
  input  logic          xfer_done_i,
  output logic          bus_req_o,
  output logic          master_o,
  output logic          xfer_o,
  output logic          dir_o
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [CW-1:0] CNT_MAX = '1;

  burst_st_e     st_q;
  logic          dir_q;
  logic [CW-1:0] cnt_q;
  logic          need;
  logic          dir_tx;
  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] limit;
  logic          count_hit, timer_hit, tx_stop, rx_stop, stop;

  dma_burst_arb #(.DEPTH(DEPTH)) u_arb (
    .tx_level_i   (tx_level_i),
    .rx_level_i   (rx_level_i),
    .rx_wm_i      (rx_wm_i),
    .tx_wm_code_i (tx_wm_code_i),
    .need_o       (need),
    .dir_tx_o     (dir_tx)
  );

  assign tmr_load = (st_q == ST_REQ) && grant_i;

  dma_burst_timer #(.DIV(TICK_DIV), .TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (timer_val_i),
    .run_i  (master_o),
    .zero_o (tmr_zero)
  );

  assign limit     = (burst_len_i == '0) ? CW'(DEF_BURST) : burst_len_i;
  assign count_hit = !fill_mode_i && !timer_en_i && (cnt_q >= limit);
  assign timer_hit = timer_en_i && tmr_zero && (cnt_q != '0);
  assign tx_stop   = dir_q && (tx_level_i >= tx_hi_i || tx_level_i >= DEPTH_L);
  assign rx_stop   = !dir_q && (rx_level_i <= rx_lo_i || rx_level_i == '0);
  assign stop      = count_hit | timer_hit | tx_stop | rx_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      dir_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (need) begin
          st_q  <= ST_REQ;
          dir_q <= dir_tx;
        end
        ST_REQ: if (grant_i) begin
          st_q  <= ST_ISSUE;
          cnt_q <= '0;
        end
        ST_ISSUE: st_q <= stop ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (xfer_done_i) begin
          st_q  <= ST_ISSUE;
          cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o = (st_q == ST_REQ);
  assign master_o  = (st_q == ST_ISSUE) || (st_q == ST_WAIT);
  assign xfer_o    = (st_q == ST_ISSUE) && !stop;
  assign dir_o     = dir_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !grant_i) |=> bus_req_o); // R4
  AST_GRANT_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && grant_i) |=> master_o); // R4
  AST_DIR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o && $past(master_o)) |-> dir_o == $past(dir_o)); // R4
  AST_NO_TX_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && dir_o) |-> (tx_level_i < tx_hi_i && tx_level_i < DEPTH_L)); // R6
  AST_NO_RX_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !dir_o) |-> rx_level_i > rx_lo_i); // R7
  AST_COUNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !fill_mode_i && !timer_en_i) |-> cnt_q < limit); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o); // R11
  AST_TIMER_ZERO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && timer_en_i && tmr_zero) |-> cnt_q == '0); // R10

endmodule

// File: tb/dma_burst_sched_tb.sv
module dma_burst_sched_tb_top;

  localparam int DEPTH = 64;
  localparam int LW    = 7;
  localparam int DIV   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] tx_level = 7'd64, rx_level = '0, tx_hi = 7'd64, rx_lo = '0, rx_wm = 7'd8;
  logic [1:0]    wm_code = 2'b00;
  logic [7:0]    blen = '0;
  logic          fill = 1'b0, ten = 1'b0, grant = 1'b0, done = 1'b0;
  logic [15:0]   tval = '0;
  logic          bus_req, master, xfer, dir;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_burst_sched #(.DEPTH(DEPTH), .TICK_DIV(DIV), .DEF_BURST(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .tx_hi_i(tx_hi), .rx_lo_i(rx_lo), .rx_wm_i(rx_wm), .tx_wm_code_i(wm_code),
    .burst_len_i(blen), .fill_mode_i(fill), .timer_en_i(ten), .timer_val_i(tval),
    .grant_i(grant), .xfer_done_i(done), .bus_req_o(bus_req), .master_o(master),
    .xfer_o(xfer), .dir_o(dir)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic neutral();
    tx_level = 7'd64;
    rx_level = '0;
  endtask

  // model of the bus and FIFOs; returns transfers, direction and master cycles
  task automatic burst(input int gdly, input int lat, output int n, output int d, output int mcyc);
    int t = 0;
    int wcnt = 0;
    int hi = int'(tx_hi);
    int lo = int'(rx_lo);
    bit bad6 = 0, bad7 = 0, bad11 = 0;
    n = 0; mcyc = 0; d = 0;
    while (!bus_req && t < 300) begin @(negedge clk); t++; end
    chk(bus_req == 1'b1, "R4 request raised", int'(bus_req), 1);
    for (int i = 0; i < gdly; i++) begin
      if (!bus_req || master) bad11 = 1;
      @(negedge clk);
    end
    chk(!bad11, "R4 request held until grant", int'(bad11), 0);
    bad11 = 0;
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(master == 1'b1, "R4 master after grant", int'(master), 1);
    d = int'(dir);
    while (master && mcyc < 5000) begin
      mcyc++;
      done = 1'b0;
      if (int'(dir) != d) bad11 = 1;
      if (xfer) begin
        if (wcnt > 0) bad11 = 1;
        n++;
        if (d == 1 && (int'(tx_level) >= hi || int'(tx_level) >= DEPTH)) bad6 = 1;
        if (d == 0 && int'(rx_level) <= lo) bad7 = 1;
        wcnt = lat;
      end else if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin
          done = 1'b1;
          if (d == 1) tx_level = tx_level + 7'd1;
          else rx_level = rx_level - 7'd1;
        end
      end
      @(negedge clk);
    end
    done = 1'b0;
    neutral();
    chk(!bad6, "R6 transfer at transmit threshold", int'(bad6), 0);
    chk(!bad7, "R7 transfer at receive threshold", int'(bad7), 0);
    chk(!bad11, "R11 overlap or direction change", int'(bad11), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, d, m;
    // R1: reset with a strong receive need
    rx_level = 7'd30;
    repeat (4) @(negedge clk);
    chk(!bus_req && !master && !xfer, "R1 outputs in reset",
        int'({bus_req, master, xfer}), 0);
    neutral();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_req, "R1 idle after reset", int'(bus_req), 0);

    // R5 default count of 16
    tx_level = '0; blen = '0;
    burst(2, 1, n, d, m);
    chk(d == 1, "R5 direction transmit", d, 1);
    chk(n == 16, "R5 default burst", n, 16);

    // R5 count of 5 with slow transfers
    tx_level = '0; blen = 8'd5;
    burst(6, 3, n, d, m);
    chk(n == 5, "R5 count 5", n, 5);

    // R5/R7 count 255 limited by receive FIFO draining
    rx_level = 7'd64; rx_wm = 7'd4; rx_lo = '0; blen = 8'd255;
    burst(1, 1, n, d, m);
    chk(d == 0, "R7 direction receive", d, 0);
    chk(n == 64, "R5 count 255 cut by drain", n, 64);

    // R6 transmit high threshold before count
    tx_level = 7'd20; tx_hi = 7'd28; blen = '0;
    burst(1, 2, n, d, m);
    chk(n == 8, "R6 stop at high threshold", n, 8);
    tx_hi = 7'd64;

    // R7 receive low threshold before count
    rx_level = 7'd20; rx_lo = 7'd12; blen = '0;
    burst(1, 1, n, d, m);
    chk(n == 8, "R7 stop at low threshold", n, 8);

    // R8 fill mode ignores count, both directions
    fill = 1'b1; blen = 8'd3; tx_level = '0; tx_hi = 7'd16;
    burst(1, 1, n, d, m);
    chk(n == 16, "R8 fill transmit", n, 16);
    tx_hi = 7'd64;
    rx_level = 7'd40; rx_lo = 7'd8; blen = 8'd2;
    burst(1, 2, n, d, m);
    chk(n == 32, "R8 fill receive", n, 32);
    fill = 1'b0; rx_lo = '0;

    // R2 below watermark: no request; then priority over transmit
    rx_wm = 7'd8; rx_level = 7'd7;
    repeat (5) @(negedge clk);
    chk(!bus_req, "R2 below receive watermark", int'(bus_req), 0);
    rx_level = 7'd10; tx_level = '0; blen = 8'd4;
    burst(1, 1, n, d, m);
    chk(d == 0, "R2 receive priority", d, 0);
    chk(n == 4, "R2 receive burst length", n, 4);

    // R3 coded transmit watermark, all codes
    for (int c = 0; c < 4; c++) begin
      int w;
      w = (c == 0) ? 8 : (c == 1) ? 16 : 32;
      wm_code = 2'(c);
      tx_level = 7'(DEPTH - w + 1);
      repeat (5) @(negedge clk);
      chk(!bus_req, "R3 below transmit watermark", int'(bus_req), 0);
      tx_level = 7'(DEPTH - w);
      tx_hi = tx_level;
      repeat (2) @(negedge clk);
      chk(bus_req && dir, "R3 request at transmit watermark", int'({bus_req, dir}), 3);
      burst(1, 1, n, d, m);
      chk(n == 0, "R3 zero-length at threshold", n, 0);
    end
    wm_code = 2'b00; tx_hi = 7'd64;

    // R10 timer value zero: one transfer
    ten = 1'b1; tval = '0; blen = 8'd200; tx_level = '0;
    burst(1, 1, n, d, m);
    chk(n == 1, "R10 timer zero single transfer", n, 1);

    // R9 timer of 10 ticks, count ignored
    tval = 16'd10; blen = 8'd2; tx_level = '0;
    burst(3, 2, n, d, m);
    chk(n > 2, "R9 count ignored in timer mode", n, 3);
    chk(m >= 10 * DIV && m <= 10 * DIV + 4, "R9 timer burst duration", m, 10 * DIV + 2);
    ten = 1'b0;

    repeat (4) @(negedge clk);
    chk(!bus_req && !master, "R4 idle at end", int'({bus_req, master}), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule